// File: doc/BRIEF.md
# Serial Management Frame Master

This block drives the two-wire management bus that a MAC uses to reach the registers of an external PHY. Software hands it one 32-bit frame word. The word carries a start pattern, an operation code, the PHY address, the register address, a turnaround pattern and 16 data bits. The block first sends a preamble of ones. It then shifts the frame out, most significant bit first, on the data line. The management clock is produced by dividing the system clock.

For a read, the block stops driving the data line part-way through the turnaround. The PHY then returns 16 bits, and the block writes them into the data field of the frame register. An idle flag goes low when a frame is accepted and goes high again once the last bit has been shifted. A port-enable input decides whether the clock pin and the data-line driver are active at all.

The divider ratio is selected per frame from four settings. A package function maps a system clock frequency to the recommended setting.

Top module: `mgmt_frame_master`

## Requirements
- R1: After a synchronous active-low reset, idle is 1, mdc is 0, mdio_oe is 0 and frame_rdata is 0.
- R2: A frame is sent as 32 preamble ones followed by the frame word, MSB first. The frame word fields are: bits 31:30 start (01), bits 29:28 operation, bits 27:23 PHY address, bits 22:18 register address, bits 17:16 turnaround (10), bits 15:0 data.
- R3: div_sel values 0, 1, 2 and 3 give an mdc period of 8, 16, 32 and 64 system clocks. mdc is high for half of each period, and div_sel is captured when a frame is accepted.
- R4: Each bit changes right after a falling mdc edge. Read data is sampled on the rising mdc edge.
- R5: With operation 10 (read), mdio_oe is 0 from the second turnaround bit through the last data bit. Any other operation drives all 64 bits.
- R6: After a read, frame_rdata[15:0] holds the 16 bits returned MSB first and frame_rdata[31:16] is unchanged. After any other operation, frame_rdata equals the word that was written.
- R7: idle goes low in the cycle after an accepted frame_wr. It stays low for exactly 64 × divider system clocks, then returns high.
- R8: While port_en is 0, mdc and mdio_oe stay 0, and the frame still runs to completion.
- R9: A frame_wr while idle is 0 is ignored. It changes neither the frame register nor the length of the frame in progress.
- R10: pick_div_code returns 0 below 20 MHz, 1 below 40 MHz, 2 below 80 MHz and 3 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Enables the mdc pin and the data-line driver |
| div_sel | input | 2 | Divider setting: 0 gives 8, 1 gives 16, 2 gives 32, 3 gives 64 |
| frame_wr | input | 1 | Starts a frame with frame_wdata; honoured only when idle |
| frame_wdata | input | 32 | Frame word to send |
| frame_rdata | output | 32 | Frame register; holds read data after a read |
| idle | output | 1 | High when no frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Data line as seen at the pin |
| mdio_o | output | 1 | Data value to drive |
| mdio_oe | output | 1 | Drive enable for the data line |

## Verification
The bench builds the block with its defaults: a 32-bit preamble and a base divider exponent of 3. With these values all four divider settings can be used, and the longest frame (divide by 64) takes 4096 cycles. Because of this, the bench can measure the exact frame length and mdc high time for every setting. It can also capture every bit on the line with a PHY model that answers reads, and it can hit the turnaround release point and the write-while-busy case.

// File: rtl/mgmt_pkg.sv
// Shared frame layout, operation codes and the divider recommendation.
// Assumes a 32-bit frame word sent most significant bit first.
package mgmt_pkg;
    localparam int FRAME_W = 32;

    typedef enum logic [1:0] {
        OP_RSVD0 = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_RSVD3 = 2'b11
    } mgmt_op_e;

    typedef struct packed {
        logic [1:0]  sof;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [1:0]  ta;
        logic [15:0] data;
    } mgmt_frame_t;

    // Recommended divider code for a system clock frequency in Hz.
    function automatic logic [1:0] pick_div_code(input int unsigned hz);
        if (hz < 32'd20_000_000)      return 2'd0;
        else if (hz < 32'd40_000_000) return 2'd1;
        else if (hz < 32'd80_000_000) return 2'd2;
        else                          return 2'd3;
    endfunction
endpackage

// File: rtl/mgmt_clk_phase.sv
// Management clock generator. A phase counter runs while a frame is active.
// It flags the rising edge halfway through each period and the falling edge
// at the end. The divider code is captured when a frame starts.
// Assumes DIV_BASE_LOG2 >= 1.
module mgmt_clk_phase #(
    parameter int DIV_BASE_LOG2 = 3,
    parameter int SEL_W         = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [SEL_W-1:0] div_sel,
    output logic             mdc_q,
    output logic             rise_evt,
    output logic             fall_evt
);
    localparam int NSEL  = 1 << SEL_W;
    localparam int CNT_W = DIV_BASE_LOG2 + NSEL - 1;

    logic [CNT_W-1:0] cnt;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] half_lim [NSEL];
    logic [CNT_W-1:0] full_lim [NSEL];

    // Compare limits for every divider setting
    for (genvar g = 0; g < NSEL; g++) begin : g_lim
        assign full_lim[g] = CNT_W'((1 << (DIV_BASE_LOG2 + g)) - 1);
        assign half_lim[g] = CNT_W'((1 << (DIV_BASE_LOG2 + g - 1)) - 1);
    end

    assign rise_evt = run && (cnt == half_lim[sel_q]);
    assign fall_evt = run && (cnt == full_lim[sel_q]);

    // Phase counter, clock level and captured divider code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            mdc_q <= 1'b0;
            sel_q <= '0;
        end else if (start) begin
            cnt   <= '0;
            mdc_q <= 1'b0;
            sel_q <= div_sel;
        end else if (run) begin
            if (fall_evt) begin
                cnt   <= '0;
                mdc_q <= 1'b0;
            end else begin
                cnt <= cnt + CNT_W'(1);
                if (rise_evt) mdc_q <= 1'b1;
            end
        end else begin
            cnt   <= '0;
            mdc_q <= 1'b0;
        end
    end

    AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt |-> !mdc_q); // R3
    AST_FALL_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |-> mdc_q); // R3
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt <= full_lim[sel_q]); // R3
endmodule

// File: rtl/mgmt_frame_seq.sv
// Frame sequencer. It holds the frame register and counts bits: first the
// preamble, then the frame. It launches each bit on a falling-edge event,
// releases the line for reads and shifts in read data on rising-edge events.
// Assumes rise and fall events never coincide.
module mgmt_frame_seq
    import mgmt_pkg::*;
#(
    parameter int PRE_BITS = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [FRAME_W-1:0] wdata,
    input  logic               rise_evt,
    input  logic               fall_evt,
    input  logic               sdi,
    output logic               start,
    output logic               busy,
    output logic [FRAME_W-1:0] frame_q,
    output logic               dout,
    output logic               drive
);
    localparam int TOTAL  = PRE_BITS + FRAME_W;
    localparam int BIT_W  = $clog2(TOTAL + 1);
    localparam int POS_W  = $clog2(FRAME_W);
    localparam int DATA_W = 16;

    logic [BIT_W-1:0]  bitcnt;
    logic [DATA_W-1:0] cap;
    mgmt_frame_t       fr;
    logic              is_rd;
    logic              in_data;

    assign fr      = frame_q;
    assign is_rd   = (fr.op == OP_READ);
    assign in_data = int'(bitcnt) >= PRE_BITS + FRAME_W - DATA_W;
    assign start   = wr && !busy;

    // Line value for bit k of the preamble-plus-frame sequence
    function automatic logic bit_at(input logic [BIT_W-1:0] k,
                                    input logic [FRAME_W-1:0] f);
        logic [POS_W-1:0] pos;
        if (int'(k) < PRE_BITS) return 1'b1;
        pos = POS_W'(FRAME_W - 1 - (int'(k) - PRE_BITS));
        return f[pos];
    endfunction

    // Drive enable for bit k: reads release from the second turnaround bit
    function automatic logic drive_at(input logic [BIT_W-1:0] k,
                                      input logic [FRAME_W-1:0] f);
        mgmt_frame_t ff;
        ff = f;
        if (ff.op == OP_READ && int'(k) >= PRE_BITS + FRAME_W - DATA_W - 1)
            return 1'b0;
        return 1'b1;
    endfunction

    // Frame register, bit counter, line outputs and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            bitcnt  <= '0;
            frame_q <= '0;
            dout    <= 1'b0;
            drive   <= 1'b0;
            cap     <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            bitcnt  <= '0;
            frame_q <= wdata;
            dout    <= bit_at('0, wdata);
            drive   <= drive_at('0, wdata);
            cap     <= '0;
        end else if (busy) begin
            if (rise_evt && is_rd && in_data)
                cap <= {cap[DATA_W-2:0], sdi};
            if (fall_evt) begin
                if (int'(bitcnt) == TOTAL - 1) begin
                    busy  <= 1'b0;
                    dout  <= 1'b0;
                    drive <= 1'b0;
                    if (is_rd) frame_q[DATA_W-1:0] <= cap;
                end else begin
                    bitcnt <= bitcnt + BIT_W'(1);
                    dout   <= bit_at(bitcnt + BIT_W'(1), frame_q);
                    drive  <= drive_at(bitcnt + BIT_W'(1), frame_q);
                end
            end
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !drive); // R5
    AST_RD_LINE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && is_rd && in_data |-> !drive); // R5
    AST_IDLE_HOLDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !wr |=> $stable(frame_q)); // R6
    AST_BUSY_IGNORES_WR: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(frame_q[FRAME_W-1:DATA_W])); // R9
endmodule

// File: rtl/mgmt_frame_master.sv
// Top of the management frame master. It connects the clock generator and
// the sequencer, and gates the pins with the port enable.
// Assumes mdio_i is already synchronous to clk.
module mgmt_frame_master
    import mgmt_pkg::*;
#(
    parameter int PRE_BITS      = 32,
    parameter int DIV_BASE_LOG2 = 3,
    parameter int SEL_W         = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               port_en,
    input  logic [SEL_W-1:0]   div_sel,
    input  logic               frame_wr,
    input  logic [FRAME_W-1:0] frame_wdata,
    output logic [FRAME_W-1:0] frame_rdata,
    output logic               idle,
    output logic               mdc,
    input  logic               mdio_i,
    output logic               mdio_o,
    output logic               mdio_oe
);
    logic start, busy, mdc_q, rise_evt, fall_evt, dout, drive;

    mgmt_clk_phase #(.DIV_BASE_LOG2(DIV_BASE_LOG2), .SEL_W(SEL_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .start(start), .run(busy),
        .div_sel(div_sel), .mdc_q(mdc_q), .rise_evt(rise_evt),
        .fall_evt(fall_evt));

    mgmt_frame_seq #(.PRE_BITS(PRE_BITS)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr(frame_wr), .wdata(frame_wdata),
        .rise_evt(rise_evt), .fall_evt(fall_evt), .sdi(mdio_i),
        .start(start), .busy(busy), .frame_q(frame_rdata),
        .dout(dout), .drive(drive));

    assign idle    = !busy;
    assign mdc     = mdc_q & port_en;
    assign mdio_o  = dout;
    assign mdio_oe = drive & port_en;

    AST_START_DROPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wr && idle |=> !idle); // R7
    AST_CLOCK_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !mdc); // R7
endmodule

// File: tb/test_mgmt_frame_master.sv
module test_mgmt_frame_master;
    import mgmt_pkg::*;
    localparam int PRE = 32;
    localparam int TOT = PRE + 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic port_en = 1'b1;
    logic [1:0] div_sel = 2'd0;
    logic frame_wr = 1'b0;
    logic [31:0] frame_wdata = '0;
    logic [31:0] frame_rdata;
    logic idle, mdc, mdio_o, mdio_oe;
    logic mdio_i = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [63:0] seen_bits, seen_oe;
    int rises, busy_cyc, hi_cyc, oe_cnt;
    bit idle_low_first;

    always #5 clk = ~clk;

    mgmt_frame_master i_mgmt_frame_master (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .div_sel(div_sel),
        .frame_wr(frame_wr), .frame_wdata(frame_wdata),
        .frame_rdata(frame_rdata), .idle(idle), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                       input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, op, phy, ra, 2'b10, d};
    endfunction

    // Issue one frame and act as the PHY until idle returns
    task automatic run_frame(input logic [31:0] w, input logic [15:0] resp,
                             input int inject_at, input logic [31:0] junk);
        int r;
        logic pm;
        seen_bits = '0; seen_oe = '0; busy_cyc = 0; hi_cyc = 0; oe_cnt = 0;
        @(negedge clk);
        frame_wr = 1'b1; frame_wdata = w; mdio_i = 1'b1;
        @(negedge clk);
        frame_wr = 1'b0; pm = 1'b0; r = 0;
        idle_low_first = !idle;
        while (!idle && busy_cyc < 20000) begin
            busy_cyc++;
            if (mdc) hi_cyc++;
            if (mdio_oe) oe_cnt++;
            if (mdc && !pm) begin
                if (r < 64) begin
                    seen_bits[63-r] = mdio_o;
                    seen_oe[63-r] = mdio_oe;
                end
                r++;
            end
            if (!mdc && pm)
                mdio_i = (r >= 48 && r < 64) ? resp[63-r] : 1'b1;
            pm = mdc;
            if (busy_cyc == inject_at) begin
                frame_wr = 1'b1; frame_wdata = junk;
            end else frame_wr = 1'b0;
            @(negedge clk);
        end
        frame_wr = 1'b0;
        rises = r;
    endtask

    // Compare captured line bits and enables with the expected sequence
    task automatic check_line(input logic [31:0] w, input bit rd, input string req);
        logic [63:0] eb, eo;
        for (int k = 0; k < 64; k++) begin
            eo[63-k] = !(rd && k >= PRE + 15);
            eb[63-k] = (k < PRE) ? 1'b1 : w[63-k];
        end
        check((seen_bits & eo) == (eb & eo), req, "line bits", seen_bits & eo, eb & eo);
        check(seen_oe == eo, "R5", "drive enable per bit", seen_oe, eo);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(idle === 1'b1, "R1", "idle after reset", 64'(idle), 64'd1);
        check(mdc === 1'b0 && mdio_oe === 1'b0, "R1", "mdc/oe after reset",
              {62'd0, mdc, mdio_oe}, 64'd0);
        check(frame_rdata === 32'd0, "R1", "frame_rdata after reset",
              64'(frame_rdata), 64'd0);
    endtask

    task automatic t_write();
        logic [31:0] w;
        w = mk(OP_WRITE, 5'h13, 5'h0A, 16'hC3A5);
        div_sel = 2'd0;
        run_frame(w, 16'h0, -1, '0);
        check_line(w, 1'b0, "R2");
        check(rises == TOT, "R4", "rising edges per frame", 64'(rises), 64'(TOT));
        check(frame_rdata == w, "R6", "frame register after write",
              64'(frame_rdata), 64'(w));
        check(idle_low_first, "R7", "idle low after accept", 64'(idle_low_first), 64'd1);
        check(busy_cyc == TOT * 8, "R7", "busy length div8", 64'(busy_cyc), 64'(TOT * 8));
    endtask

    task automatic t_read();
        logic [31:0] w;
        w = mk(OP_READ, 5'h01, 5'h1F, 16'hFFFF);
        div_sel = 2'd0;
        run_frame(w, 16'h9C35, -1, '0);
        check_line(w, 1'b1, "R2");
        check(frame_rdata == {w[31:16], 16'h9C35}, "R6", "read data captured",
              64'(frame_rdata), 64'({w[31:16], 16'h9C35}));
        check(oe_cnt == (PRE + 15) * 8, "R5", "driven cycles on read",
              64'(oe_cnt), 64'((PRE + 15) * 8));
        // R4: alternating pattern exposes sampling at the wrong edge
        run_frame(mk(OP_READ, 5'h04, 5'h02, 16'h0), 16'h5A0F, -1, '0);
        check(frame_rdata[15:0] == 16'h5A0F, "R4", "sampled on rising edge",
              64'(frame_rdata[15:0]), 64'h5A0F);
    endtask

    task automatic t_div_sweep();
        for (int s = 1; s < 4; s++) begin
            int n;
            n = 8 << s;
            div_sel = 2'(s);
            run_frame(mk(OP_WRITE, 5'h02, 5'h03, 16'h1234), 16'h0, -1, '0);
            check(busy_cyc == TOT * n, "R3", "frame length for divider",
                  64'(busy_cyc), 64'(TOT * n));
            check(hi_cyc == TOT * n / 2, "R3", "mdc high time", 64'(hi_cyc),
                  64'(TOT * n / 2));
        end
        div_sel = 2'd0;
    endtask

    task automatic t_port_off();
        logic [31:0] w;
        w = mk(OP_WRITE, 5'h07, 5'h05, 16'hBEEF);
        port_en = 1'b0;
        run_frame(w, 16'h0, -1, '0);
        check(rises == 0, "R8", "no mdc edges when disabled", 64'(rises), 64'd0);
        check(oe_cnt == 0, "R8", "no drive when disabled", 64'(oe_cnt), 64'd0);
        check(idle === 1'b1 && busy_cyc == TOT * 8, "R8", "frame completes",
              64'(busy_cyc), 64'(TOT * 8));
        port_en = 1'b1;
    endtask

    task automatic t_busy_ignore();
        logic [31:0] w;
        w = mk(OP_WRITE, 5'h11, 5'h09, 16'h0F0F);
        run_frame(w, 16'h0, 100, 32'h6AAA_5555);
        check(frame_rdata == w, "R9", "frame register kept", 64'(frame_rdata), 64'(w));
        check(busy_cyc == TOT * 8, "R9", "frame length unchanged",
              64'(busy_cyc), 64'(TOT * 8));
        @(negedge clk);
        check(idle === 1'b1, "R9", "no second frame started", 64'(idle), 64'd1);
    endtask

    task automatic t_div_pick();
        check(pick_div_code(19_999_999) == 2'd0, "R10", "below 20 MHz",
              64'(pick_div_code(19_999_999)), 64'd0);
        check(pick_div_code(20_000_000) == 2'd1, "R10", "at 20 MHz",
              64'(pick_div_code(20_000_000)), 64'd1);
        check(pick_div_code(39_999_999) == 2'd1, "R10", "below 40 MHz",
              64'(pick_div_code(39_999_999)), 64'd1);
        check(pick_div_code(40_000_000) == 2'd2, "R10", "at 40 MHz",
              64'(pick_div_code(40_000_000)), 64'd2);
        check(pick_div_code(80_000_000) == 2'd3, "R10", "at 80 MHz",
              64'(pick_div_code(80_000_000)), 64'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write();
        t_read();
        t_div_sweep();
        t_port_off();
        t_busy_ignore();
        t_div_pick();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule